// File: doc/BRIEF.md
# Interrupt Source Router

This block sits between a set of interrupt request lines and the per-CPU delivery logic of a multiprocessor interrupt controller. Each source has two configuration words. The priority word holds the mask, priority and vector, and it reports the fixed sensing and delivery properties of the source. The destination word holds the CPU set the source may target. The block samples each request line, keeps a pending flag and an activity flag per source, and decides which CPU or CPUs receive a one-cycle raise strobe. Each strobe carries the source index and priority.

Sources are fixed at build time as edge or level sensitive, active high or active low, and directed or distributed. A directed source goes to every CPU in its destination set. A distributed source goes to one CPU, chosen by a rotating search that starts after the CPU it used last. When several sources are ready in the same cycle, the lowest-indexed one is delivered first. The acknowledge logic downstream returns an index strobe that clears the activity flag of a source, and that also clears the pending flag of an edge source.

Top module: `irq_route`

## Requirements
- R1: After reset every priority word reads with bit 31 (mask) set, bit 30 (activity) and priority/vector clear. Bit 29 reads 1 for distributed sources, bit 23 reads 1 for active-high sources and bit 22 reads 1 for level sources (defaults: source 1 and 3 distributed, source 2 level, all active high). Every destination word reads 0x00000001 and no raise strobe is high.
- R2: A write to a priority word (select 0) updates only bit 31 (mask), bits 19:16 (priority) and bits 15:0 (vector). Bits 30, 29, 23 and 22 keep their values.
- R3: A source raises nothing while it is not pending, masked, at priority 0, already active, or has an all-zero CPU set. A pending edge source stays pending while it is held off, and it is delivered one cycle after the blocking condition is removed.
- R4: A directed source (bit 29 = 0) raises every CPU whose bit is set in the low destination bits, all in the same cycle. Each raised CPU sees the source index and the priority.
- R5: A distributed source (bit 29 = 1) raises one CPU: the first set destination bit found searching upward from the CPU after the last one used, wrapping around. That CPU becomes the new last CPU; the last CPU is 0 after reset. A destination equal to exactly the last CPU's bit delivers to that CPU.
- R6: For an edge source, a rising level sampled at clock edge n sets pending at edge n+1, and the raise strobe is high after edge n+2. Falling edges have no effect.
- R7: For a level source, pending follows the sampled level. A low level also clears the activity bit.
- R8: An acknowledge strobe clears the activity bit of the indexed source and, for edge sources, its pending flag. A level source still held high is raised again one cycle after the acknowledge.
- R9: A write to a destination word (select 1) keeps only bits 31 and 30 and the low NUM_CPU bits. All other bits read 0.
- R10: The activity bit is set at the clock edge that drives the raise strobe. The strobe lasts one cycle, and at most one source is delivered per cycle, lowest index first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_SRC | Raw request lines, one per source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dst_sel | input | 1 | 0 selects the priority word, 1 the destination word |
| cfg_idx | input | SRC_W | Source index of the write |
| cfg_wdata | input | 32 | Write data |
| rd_idx | input | SRC_W | Source index of the read |
| rd_dst_sel | input | 1 | 0 reads the priority word, 1 the destination word |
| rd_data | output | 32 | Read data (combinational) |
| ack_vld | input | 1 | Acknowledge strobe from the per-CPU logic |
| ack_idx | input | SRC_W | Source index being acknowledged |
| raise_vld | output | NUM_CPU | One-cycle raise strobe per CPU |
| raise_src | output | NUM_CPU*SRC_W | Source index per CPU, CPU c at bits c*SRC_W |
| raise_prio | output | NUM_CPU*4 | Priority per CPU, CPU c at bits c*4 |

## Verification
A directed source is driven with two-CPU and one-CPU destination sets, so that broadcast can be told apart from single delivery. A distributed source is pulsed repeatedly with a sparse CPU set, which exposes an error in the wrap and skip order of the rotating search. Each blocking condition (mask, zero priority, empty set, activity) is applied alone while a pulse arrives and is then lifted, which separates a lost pending flag from a stuck one. A held-high level source acknowledged while still high, plus two sources pulsed in the same cycle, check redelivery and the lowest-index-first order.

// File: rtl/irq_route_pkg.sv
// Shared field positions of the per-source configuration words.
// Assumes 32-bit words and a CPU count of at most 30.
package irq_route_pkg;
    localparam int WORD_W      = 32;
    localparam int PRIO_W      = 4;
    localparam int VEC_W       = 16;
    localparam int VP_MASK_BIT = 31;
    localparam int VP_ACT_BIT  = 30;
    localparam int VP_MODE_BIT = 29;
    localparam int VP_POL_BIT  = 23;
    localparam int VP_SENS_BIT = 22;
    localparam int VP_PRIO_LSB = 16;
    localparam int DST_EXT_BIT = 31;
    localparam int DST_CRI_BIT = 30;
endpackage

// File: rtl/irq_target_sel.sv
// Works out the CPU set one source would raise: the last CPU alone when the
// destination names only it, the whole destination set in directed mode, or
// the next set CPU after the last one in distributed mode.
// Assumes NUM_CPU >= 2.
module irq_target_sel #(
    parameter int NUM_CPU = 4,
    parameter int CPU_W   = 2
) (
    input  logic [NUM_CPU-1:0] dst_cpu,
    input  logic [CPU_W-1:0]   last_cpu,
    input  logic               distrib,
    output logic [NUM_CPU-1:0] targets,
    output logic [CPU_W-1:0]   rr_pick
);
    logic [NUM_CPU-1:0] last_hot;

    // One-hot form of the last CPU used.
    always_comb begin
        last_hot = {{(NUM_CPU-1){1'b0}}, 1'b1} << last_cpu;
    end

    // Rotating search: the smallest step from last_cpu that hits a set bit wins.
    always_comb begin
        int c;
        c       = 0;
        rr_pick = last_cpu;
        for (int k = NUM_CPU; k >= 1; k--) begin
            c = (int'(last_cpu) + k) % NUM_CPU;
            if (dst_cpu[c]) rr_pick = CPU_W'(c);
        end
    end

    // Final target set from the three delivery cases.
    always_comb begin
        if (dst_cpu == last_hot)
            targets = last_hot;
        else if (!distrib)
            targets = dst_cpu;
        else
            targets = {{(NUM_CPU-1){1'b0}}, 1'b1} << rr_pick;
    end
endmodule

// File: rtl/irq_src_slot.sv
// State of one interrupt source: input sampling, pending and activity flags,
// the two configuration words and the last CPU used by distributed delivery.
// Assumes grant never coincides with ack for the same source (the eligible
// output is already cleared by ack).
module irq_src_slot
    import irq_route_pkg::*;
#(
    parameter int NUM_CPU     = 4,
    parameter int CPU_W       = 2,
    parameter bit IS_LEVEL    = 1'b0,
    parameter bit IS_DISTRIB  = 1'b0,
    parameter bit IS_ACT_HIGH = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               irq_raw,
    input  logic               we_vp,
    input  logic               we_dst,
    input  logic [WORD_W-1:0]  wdata,
    input  logic               grant,
    input  logic               ack,
    output logic [WORD_W-1:0]  vp_word,
    output logic [WORD_W-1:0]  dst_word,
    output logic               eligible,
    output logic               active_o,
    output logic [PRIO_W-1:0]  prio_o,
    output logic [NUM_CPU-1:0] targets
);
    logic               s_lvl, s_prev;
    logic               pending, active;
    logic               mask_q;
    logic [PRIO_W-1:0]  prio_q;
    logic [VEC_W-1:0]   vec_q;
    logic               dst_ext, dst_cri;
    logic [NUM_CPU-1:0] dst_cpu;
    logic [CPU_W-1:0]   last_cpu;
    logic [CPU_W-1:0]   rr_pick;
    logic               wdata_unused;

    assign wdata_unused = ^wdata;

    // Register the request line in its asserted sense and keep the prior sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_lvl  <= 1'b0;
            s_prev <= 1'b0;
        end else begin
            s_lvl  <= IS_ACT_HIGH ? irq_raw : ~irq_raw;
            s_prev <= s_lvl;
        end
    end

    // Pending: follows the level, or is set by a rising edge and cleared by ack.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending <= 1'b0;
        else if (IS_LEVEL)
            pending <= s_lvl;
        else if (s_lvl && !s_prev)
            pending <= 1'b1;
        else if (ack)
            pending <= 1'b0;
    end

    // Activity: set on delivery, cleared by ack or by a low level.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active <= 1'b0;
        else if (grant)
            active <= 1'b1;
        else if (ack || (IS_LEVEL && !s_lvl))
            active <= 1'b0;
    end

    // Priority word: only mask, priority and vector are writable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= 1'b1;
            prio_q <= '0;
            vec_q  <= '0;
        end else if (we_vp) begin
            mask_q <= wdata[VP_MASK_BIT];
            prio_q <= wdata[VP_PRIO_LSB +: PRIO_W];
            vec_q  <= wdata[VEC_W-1:0];
        end
    end

    // Destination word: two flag bits and the CPU set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_ext <= 1'b0;
            dst_cri <= 1'b0;
            dst_cpu <= {{(NUM_CPU-1){1'b0}}, 1'b1};
        end else if (we_dst) begin
            dst_ext <= wdata[DST_EXT_BIT];
            dst_cri <= wdata[DST_CRI_BIT];
            dst_cpu <= wdata[NUM_CPU-1:0];
        end
    end

    // Remember the CPU chosen by a distributed delivery.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_cpu <= '0;
        else if (grant && IS_DISTRIB)
            last_cpu <= rr_pick;
    end

    irq_target_sel #(
        .NUM_CPU (NUM_CPU),
        .CPU_W   (CPU_W)
    ) i_sel (
        .dst_cpu  (dst_cpu),
        .last_cpu (last_cpu),
        .distrib  (IS_DISTRIB),
        .targets  (targets),
        .rr_pick  (rr_pick)
    );

    // Ready for delivery this cycle.
    always_comb begin
        eligible = pending && !mask_q && (prio_q != '0) && !active
                   && (dst_cpu != '0) && !ack;
    end

    // Read-back images of both words.
    always_comb begin
        vp_word                         = '0;
        vp_word[VP_MASK_BIT]            = mask_q;
        vp_word[VP_ACT_BIT]             = active;
        vp_word[VP_MODE_BIT]            = IS_DISTRIB;
        vp_word[VP_POL_BIT]             = IS_ACT_HIGH;
        vp_word[VP_SENS_BIT]            = IS_LEVEL;
        vp_word[VP_PRIO_LSB +: PRIO_W]  = prio_q;
        vp_word[VEC_W-1:0]              = vec_q;
        dst_word                        = '0;
        dst_word[DST_EXT_BIT]           = dst_ext;
        dst_word[DST_CRI_BIT]           = dst_cri;
        dst_word[NUM_CPU-1:0]           = dst_cpu;
    end

    assign active_o = active;
    assign prio_o   = prio_q;
endmodule

// File: rtl/irq_deliver_arb.sv
// Picks the lowest-indexed eligible source each cycle and registers one
// raise strobe per targeted CPU with the source index and priority.
// Assumes targets and priorities arrive flattened, source-major.
module irq_deliver_arb
    import irq_route_pkg::*;
#(
    parameter int NUM_SRC = 4,
    parameter int NUM_CPU = 4,
    parameter int SRC_W   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_SRC-1:0]         eligible,
    input  logic [NUM_SRC*NUM_CPU-1:0] tgt_flat,
    input  logic [NUM_SRC*PRIO_W-1:0]  prio_flat,
    output logic [NUM_SRC-1:0]         grant,
    output logic [NUM_CPU-1:0]         raise_vld,
    output logic [NUM_CPU*SRC_W-1:0]   raise_src,
    output logic [NUM_CPU*PRIO_W-1:0]  raise_prio
);
    logic [SRC_W-1:0] sel;
    logic             any;

    // Fixed-priority pick: lowest index wins.
    always_comb begin
        grant = '0;
        sel   = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (eligible[i]) sel = SRC_W'(i);
        end
        any = |eligible;
        if (any) grant[sel] = 1'b1;
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic hit;
        assign hit = any && tgt_flat[int'(sel)*NUM_CPU + c];

        // Register the strobe and its payload for CPU c.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                raise_vld[c]                     <= 1'b0;
                raise_src[c*SRC_W +: SRC_W]      <= '0;
                raise_prio[c*PRIO_W +: PRIO_W]   <= '0;
            end else begin
                raise_vld[c]                     <= hit;
                raise_src[c*SRC_W +: SRC_W]      <= hit ? sel : '0;
                raise_prio[c*PRIO_W +: PRIO_W]   <= hit ? prio_flat[int'(sel)*PRIO_W +: PRIO_W] : '0;
            end
        end
    end
endmodule

// File: rtl/irq_route.sv
// Top of the interrupt source router: one slot per source, a write/read port
// for the configuration words, an acknowledge input and the delivery arbiter.
// Assumes 2 <= NUM_CPU <= 30 and NUM_SRC >= 1.
module irq_route
    import irq_route_pkg::*;
#(
    parameter int                  NUM_SRC      = 4,
    parameter int                  NUM_CPU      = 4,
    parameter logic [NUM_SRC-1:0]  LEVEL_SRC    = 4'b0100,
    parameter logic [NUM_SRC-1:0]  DISTRIB_SRC  = 4'b1010,
    parameter logic [NUM_SRC-1:0]  ACT_HIGH_SRC = 4'b1111,
    localparam int                 SRC_W        = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int                 CPU_W        = $clog2(NUM_CPU)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        irq_in,
    input  logic                      cfg_we,
    input  logic                      cfg_dst_sel,
    input  logic [SRC_W-1:0]          cfg_idx,
    input  logic [WORD_W-1:0]         cfg_wdata,
    input  logic [SRC_W-1:0]          rd_idx,
    input  logic                      rd_dst_sel,
    output logic [WORD_W-1:0]         rd_data,
    input  logic                      ack_vld,
    input  logic [SRC_W-1:0]          ack_idx,
    output logic [NUM_CPU-1:0]        raise_vld,
    output logic [NUM_CPU*SRC_W-1:0]  raise_src,
    output logic [NUM_CPU*PRIO_W-1:0] raise_prio
);
    logic [WORD_W-1:0]          vp_words  [NUM_SRC];
    logic [WORD_W-1:0]          dst_words [NUM_SRC];
    logic [NUM_SRC-1:0]         src_elig, src_grant, src_active, ack_hit;
    logic [NUM_SRC*NUM_CPU-1:0] tgt_flat;
    logic [NUM_SRC*PRIO_W-1:0]  prio_flat;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        logic we_vp, we_dst;

        // Decode this source's write enables and acknowledge.
        always_comb begin
            we_vp      = cfg_we && (cfg_idx == SRC_W'(i)) && !cfg_dst_sel;
            we_dst     = cfg_we && (cfg_idx == SRC_W'(i)) &&  cfg_dst_sel;
            ack_hit[i] = ack_vld && (ack_idx == SRC_W'(i));
        end

        irq_src_slot #(
            .NUM_CPU     (NUM_CPU),
            .CPU_W       (CPU_W),
            .IS_LEVEL    (LEVEL_SRC[i]),
            .IS_DISTRIB  (DISTRIB_SRC[i]),
            .IS_ACT_HIGH (ACT_HIGH_SRC[i])
        ) i_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .irq_raw  (irq_in[i]),
            .we_vp    (we_vp),
            .we_dst   (we_dst),
            .wdata    (cfg_wdata),
            .grant    (src_grant[i]),
            .ack      (ack_hit[i]),
            .vp_word  (vp_words[i]),
            .dst_word (dst_words[i]),
            .eligible (src_elig[i]),
            .active_o (src_active[i]),
            .prio_o   (prio_flat[i*PRIO_W +: PRIO_W]),
            .targets  (tgt_flat[i*NUM_CPU +: NUM_CPU])
        );
    end

    irq_deliver_arb #(
        .NUM_SRC (NUM_SRC),
        .NUM_CPU (NUM_CPU),
        .SRC_W   (SRC_W)
    ) i_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .eligible   (src_elig),
        .tgt_flat   (tgt_flat),
        .prio_flat  (prio_flat),
        .grant      (src_grant),
        .raise_vld  (raise_vld),
        .raise_src  (raise_src),
        .raise_prio (raise_prio)
    );

    // Read mux over the configuration words; out-of-range reads return zero.
    always_comb begin
        if (int'(rd_idx) < NUM_SRC)
            rd_data = rd_dst_sel ? dst_words[rd_idx] : vp_words[rd_idx];
        else
            rd_data = '0;
    end
endmodule

// File: rtl/irq_route_chk.sv
// Checker for the interrupt source router, bound to every instance of the top.
// Assumes it sees the arbiter grant and the slot activity flags.
module irq_route_chk #(
    parameter int                 NUM_SRC     = 4,
    parameter int                 NUM_CPU     = 4,
    parameter int                 PRIO_W      = 4,
    parameter logic [NUM_SRC-1:0] DISTRIB_SRC = '0
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [NUM_SRC-1:0]        grant,
    input logic [NUM_SRC-1:0]        active,
    input logic [NUM_CPU-1:0]        raise_vld,
    input logic [NUM_CPU*PRIO_W-1:0] raise_prio
);
    p_grant_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    p_active_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |=> ((active & $past(grant)) == $past(grant)));

    p_raise_after_grant_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_vld != '0) |-> ($past(grant) != '0));

    p_distrib_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((grant & DISTRIB_SRC) != '0) |=> ($countones(raise_vld) == 1));

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src_chk
        p_no_regrant_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
            grant[i] |-> !active[i]);
    end

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu_chk
        p_raise_prio_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
            raise_vld[c] |-> (raise_prio[c*PRIO_W +: PRIO_W] != '0));
    end
endmodule

bind irq_route irq_route_chk #(
    .NUM_SRC     (NUM_SRC),
    .NUM_CPU     (NUM_CPU),
    .PRIO_W      (irq_route_pkg::PRIO_W),
    .DISTRIB_SRC (DISTRIB_SRC)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .grant      (src_grant),
    .active     (src_active),
    .raise_vld  (raise_vld),
    .raise_prio (raise_prio)
);

// File: tb/test_irq_route.sv
module test_irq_route;
    localparam int NS = 4;
    localparam int NC = 4;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] irq_in = '0;
    logic          cfg_we = 1'b0, cfg_dst_sel = 1'b0;
    logic [SW-1:0] cfg_idx = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [SW-1:0] rd_idx = '0;
    logic          rd_dst_sel = 1'b0;
    logic [31:0]   rd_data;
    logic          ack_vld = 1'b0;
    logic [SW-1:0] ack_idx = '0;
    logic [NC-1:0] raise_vld;
    logic [NC*SW-1:0] raise_src;
    logic [NC*4-1:0]  raise_prio;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    irq_route i_irq_route (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .cfg_we(cfg_we), .cfg_dst_sel(cfg_dst_sel), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .rd_idx(rd_idx), .rd_dst_sel(rd_dst_sel), .rd_data(rd_data),
        .ack_vld(ack_vld), .ack_idx(ack_idx),
        .raise_vld(raise_vld), .raise_src(raise_src), .raise_prio(raise_prio)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(int idx, bit dsel, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_dst_sel = dsel; cfg_idx = SW'(idx); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(int idx, bit dsel, output logic [31:0] v);
        rd_idx = SW'(idx); rd_dst_sel = dsel;
        #1 v = rd_data;
    endtask

    task automatic ack(int idx);
        @(negedge clk);
        ack_vld = 1'b1; ack_idx = SW'(idx);
        @(negedge clk);
        ack_vld = 1'b0;
    endtask

    // Low for one cycle, then high; returns at the negedge where it rose.
    task automatic pulse(int idx);
        @(negedge clk); irq_in[idx] = 1'b0;
        @(negedge clk); irq_in[idx] = 1'b1;
    endtask

    function automatic logic [31:0] src_of(int c);
        return 32'(raise_src[c*SW +: SW]);
    endfunction

    function automatic logic [31:0] prio_of(int c);
        return 32'(raise_prio[c*4 +: 4]);
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 raise idle", 32'(raise_vld), 0);
        rd(0, 0, v); chk("R1 vp src0", v, 32'h8080_0000);
        rd(1, 0, v); chk("R1 vp src1", v, 32'hA080_0000);
        rd(2, 0, v); chk("R1 vp src2", v, 32'h80C0_0000);
        rd(3, 1, v); chk("R1 dst src3", v, 32'h0000_0001);
    endtask

    task automatic t_vp_write();
        logic [31:0] v;
        wr(2, 0, 32'hFFFF_FFFF); rd(2, 0, v); chk("R2 vp fields src2", v, 32'h80CF_FFFF);
        wr(1, 0, 32'h1FFF_FFFF); rd(1, 0, v); chk("R2 vp fields src1", v, 32'h208F_FFFF);
        wr(2, 0, 32'h8000_0000);
        wr(1, 0, 32'h8000_0000);
    endtask

    task automatic t_dst_write();
        logic [31:0] v;
        wr(3, 1, 32'hFFFF_FFFF); rd(3, 1, v); chk("R9 dst kept bits", v, 32'hC000_000F);
        wr(3, 1, 32'h3FFF_FFF2); rd(3, 1, v); chk("R9 dst dropped bits", v, 32'h0000_0002);
        wr(3, 1, 32'h0000_0001);
    endtask

    task automatic t_directed();
        logic [31:0] v;
        wr(0, 1, 32'h5); wr(0, 0, 32'h0005_1234);
        pulse(0);
        repeat (2) @(negedge clk);
        chk("R6 no raise before edge n+2", 32'(raise_vld), 0);
        @(negedge clk);
        chk("R4 directed cpus", 32'(raise_vld), 32'h5);
        chk("R4 cpu0 src", src_of(0), 0);
        chk("R4 cpu2 prio", prio_of(2), 5);
        rd(0, 0, v); chk("R10 activity with strobe", v, 32'h4085_1234);
        @(negedge clk);
        chk("R10 single-cycle strobe", 32'(raise_vld), 0);
        ack(0);
        rd(0, 0, v); chk("R8 ack clears activity", v, 32'h0085_1234);
        repeat (3) @(negedge clk);
        chk("R8 edge pending cleared", 32'(raise_vld), 0);
        irq_in[0] = 1'b0;
        repeat (4) @(negedge clk);
        chk("R6 falling edge ignored", 32'(raise_vld), 0);
    endtask

    task automatic t_gates();
        int seen;
        // mask
        wr(0, 0, 32'h8005_1234); pulse(0);
        seen = 0;
        repeat (5) begin @(negedge clk); seen += int'(raise_vld != 0); end
        chk("R3 masked holds off", 32'(seen), 0);
        wr(0, 0, 32'h0005_1234); @(negedge clk);
        chk("R3 unmask delivers held pending", 32'(raise_vld), 32'h5);
        ack(0);
        // zero priority
        wr(0, 0, 32'h0000_1234); pulse(0);
        seen = 0;
        repeat (5) begin @(negedge clk); seen += int'(raise_vld != 0); end
        chk("R3 priority zero holds off", 32'(seen), 0);
        wr(0, 0, 32'h0003_1234); @(negedge clk);
        chk("R3 priority restored", 32'(raise_vld), 32'h5);
        chk("R3 new priority carried", prio_of(0), 3);
        ack(0);
        // empty destination
        wr(0, 1, 32'h0); wr(0, 0, 32'h0005_1234); pulse(0);
        seen = 0;
        repeat (5) begin @(negedge clk); seen += int'(raise_vld != 0); end
        chk("R3 empty set holds off", 32'(seen), 0);
        wr(0, 1, 32'h1); @(negedge clk);
        chk("R3 set restored", 32'(raise_vld), 32'h1);
        // already active: no second delivery
        pulse(0);
        seen = 0;
        repeat (5) begin @(negedge clk); seen += int'(raise_vld != 0); end
        chk("R3 active holds off", 32'(seen), 0);
        ack(0);
        repeat (2) @(negedge clk);
        chk("R8 ack drops pending edge", 32'(raise_vld), 0);
    endtask

    task automatic t_distrib();
        int exp_cpu [4] = '{1, 3, 0, 1};
        wr(1, 1, 32'hB); wr(1, 0, 32'h0006_0042);
        foreach (exp_cpu[k]) begin
            pulse(1);
            repeat (3) @(negedge clk);
            chk($sformatf("R5 rotate step %0d", k), 32'(raise_vld), 32'(1) << exp_cpu[k]);
            chk("R5 source index", src_of(exp_cpu[k]), 1);
            ack(1);
        end
        wr(1, 1, 32'h2); pulse(1); repeat (3) @(negedge clk);
        chk("R5 destination is last cpu", 32'(raise_vld), 32'h2);
        ack(1);
        wr(1, 1, 32'h4); pulse(1); repeat (3) @(negedge clk);
        chk("R5 single other cpu", 32'(raise_vld), 32'h4);
        ack(1);
        wr(1, 1, 32'h6); pulse(1); repeat (3) @(negedge clk);
        chk("R5 wraps after cpu2", 32'(raise_vld), 32'h2);
        ack(1);
    endtask

    task automatic t_level();
        logic [31:0] v;
        int seen;
        wr(2, 1, 32'h8); wr(2, 0, 32'h0007_00AA);
        @(negedge clk); irq_in[2] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R7 level raise", 32'(raise_vld), 32'h8);
        chk("R7 level prio", prio_of(3), 7);
        chk("R7 level src", src_of(3), 2);
        seen = 0;
        repeat (4) begin @(negedge clk); seen += int'(raise_vld != 0); end
        chk("R7 held high while active", 32'(seen), 0);
        ack(2); @(negedge clk);
        chk("R8 level redelivered after ack", 32'(raise_vld), 32'h8);
        @(negedge clk); irq_in[2] = 1'b0;
        repeat (2) @(negedge clk);
        rd(2, 0, v); chk("R7 low level clears activity", v, 32'h00C7_00AA);
        seen = 0;
        repeat (4) begin @(negedge clk); seen += int'(raise_vld != 0); end
        chk("R7 low level not pending", 32'(seen), 0);
    endtask

    task automatic t_arb();
        wr(3, 0, 32'h0002_0077);
        @(negedge clk); irq_in[0] = 1'b0; irq_in[3] = 1'b0;
        @(negedge clk); irq_in[0] = 1'b1; irq_in[3] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 lowest index first", src_of(0), 0);
        chk("R10 first prio", prio_of(0), 5);
        @(negedge clk);
        chk("R10 second cycle valid", 32'(raise_vld), 32'h1);
        chk("R10 second source", src_of(0), 3);
        chk("R10 second prio", prio_of(0), 2);
        ack(0); ack(3);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_vp_write();
        t_dst_write();
        t_directed();
        t_gates();
        t_distrib();
        t_level();
        t_arb();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end
endmodule